// File: doc/BRIEF.md
# Programmable Parallel I/O Controller

This block gives a host three 8-bit parallel ports (A, B and C) behind a two-bit register address. Address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the control word. A control write with bit 7 set is a mode word. It fixes the mode and direction of each port group. A control write with bit 7 clear is a single-bit command that sets or clears one port C bit.

Port C serves two roles. Some of its bits carry handshake status for the strobed modes, and the rest are plain I/O. On every mode word the block rebuilds two masks from the new mode. The writable mask says which port C bits the host may change. The drive mask says which bits appear on the pins. A mode word also clears the latches of any group whose mode changed. Port B has a single-strobe handshake model of its own. The full port A handshake engine sits outside this block. This block only reserves the port C positions that engine uses and reports the port A pins on reads.

Top module: `pio_ctrl`

## Requirements
- R1: After reset the control word is 0x1B, so all ports are inputs. pa_oe, pb_oe and pc_oe are all zero, the port C latch is 0x00, and every port C bit is host-writable.
- R2: Mode word bits are: 6 = port A bidirectional, 5 = port A strobed, 4 = port A input, 3 = port C upper nibble input, 2 = port B strobed, 1 = port B input, 0 = port C lower nibble input. pa_oe is 1 when bit 6 is 1 or bit 4 is 0. pb_oe is 1 when bit 1 is 0.
- R3: The masks come from the mode word. A general-purpose port C bit is both writable and driven only if its nibble is an output.
  - Port A mode 0: bits 7:4 are general-purpose.
  - Port A strobed input: drives 0x28, writable 0x10, and bits 7:6 are general-purpose.
  - Port A strobed output: drives 0x88, writable 0x40, and bits 5:4 are general-purpose.
  - Port A bidirectional: drives 0xA8, writable 0x50.
  - Port B mode 0: bits 2:0 are general-purpose.
  - Port B strobed: drives 0x03, writable 0x04.
  - Bit 3 is general-purpose only while port A is in mode 0. It is never writable while bit 5 or bit 6 is set.
- R4: pc_out equals the port C latch ANDed with pc_oe. A write to address 2 changes only the writable bits.
- R5: A control write with bit 7 clear picks port C bit wdata[3:1] and gives it the value wdata[0]. Only that bit changes, and only if it is writable. Otherwise nothing changes.
- R6: A mode word that changes bits 6:5 clears the port A latch and port C bits 7:4.
- R7: A mode word that changes bit 2 clears the port B latch and port C bits 2:0. It also clears bit 3, unless the new mode has bit 5 or bit 6 set.
- R8: In port B strobed mode a pb_stb pulse sets port C bit 1 (flag). It also sets bit 0 (interrupt) if bit 2 (enable) is 1. In input direction the pulse captures pb_in into the port B latch, and a host read of port B clears bits 1:0. In output direction a host write of port B clears bits 1:0.
- R9: Reads return the following:
  - Port A: pa_in when bit 6 or bit 4 is set, otherwise the port A latch.
  - Port B: pb_in in mode 0 input, otherwise the port B latch.
  - Port C: the port C latch.
  - Address 3: 0xFF.
- R10: A port B write while port B is an input (bit 1 = 1) is ignored and leaves the latch unchanged.
- R11: If a mode word and pb_stb arrive in the same cycle, the mode word wins and the strobe has no effect.
- R12: A port A write always loads the port A latch, whatever the direction. pa_out equals the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Host write strobe, one cycle |
| rd_en | input | 1 | Host read strobe; read side effects apply at the clock edge |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data for addr (combinational) |
| pa_in | input | 8 | Port A pins |
| pa_out | output | 8 | Port A latch |
| pa_oe | output | 1 | Port A output enable |
| pb_in | input | 8 | Port B pins |
| pb_out | output | 8 | Port B latch |
| pb_oe | output | 1 | Port B output enable |
| pb_stb | input | 1 | Port B peripheral strobe (input) or acknowledge (output), one cycle |
| pc_out | output | 8 | Port C pin values |
| pc_oe | output | 8 | Port C per-bit drive enables |

## Verification
The assertions assume the following about the host and peripheral:
- wr_en and rd_en are never high in the same cycle.
- pb_stb is a single-cycle pulse.
- The address is stable while a strobe is high.

The stimulus follows these rules. Every bus operation and strobe is a one-cycle pulse launched at the falling clock edge. A strobe overlaps a control write only in the one case that tests R11. Reset is asserted before each of the 128 mode words in the mask sweep, so every combination starts from the same clean latch.

// File: rtl/pio_pkg.sv
package pio_pkg;
   typedef struct packed {
      logic a_bidir;
      logic a_strobed;
      logic a_input;
      logic cu_input;
      logic b_strobed;
      logic b_input;
      logic cl_input;
   } pio_mode_t;

   localparam int unsigned PC_B_INTR = 0;
   localparam int unsigned PC_B_FLAG = 1;
   localparam int unsigned PC_B_EN   = 2;
   localparam int unsigned PC_A_INTR = 3;
   localparam int unsigned PC_A_ENI  = 4;
   localparam int unsigned PC_A_IBF  = 5;
   localparam int unsigned PC_A_ENO  = 6;
   localparam int unsigned PC_A_OBF  = 7;

   localparam logic [1:0] ADR_A   = 2'd0;
   localparam logic [1:0] ADR_B   = 2'd1;
   localparam logic [1:0] ADR_C   = 2'd2;
   localparam logic [1:0] ADR_CTL = 2'd3;
endpackage

// File: rtl/pio_mask_gen.sv
module pio_mask_gen
   import pio_pkg::*;
#(
   parameter int unsigned DW = 8
)(
   input  pio_mode_t       mode,
   output logic [DW-1:0]   wmask,
   output logic [DW-1:0]   omask
);
   localparam logic [DW-1:0] HI_NIB   = DW'(8'hF0);
   localparam logic [DW-1:0] LO3      = DW'(8'h07);
   localparam logic [DW-1:0] BIT3     = DW'(8'h08);
   localparam logic [DW-1:0] A_BI_O   = DW'(8'hA8);
   localparam logic [DW-1:0] A_BI_W   = DW'(8'h50);
   localparam logic [DW-1:0] A_SI_O   = DW'(8'h28);
   localparam logic [DW-1:0] A_SI_W   = DW'(8'h10);
   localparam logic [DW-1:0] A_SI_GP  = DW'(8'hC0);
   localparam logic [DW-1:0] A_SO_O   = DW'(8'h88);
   localparam logic [DW-1:0] A_SO_W   = DW'(8'h40);
   localparam logic [DW-1:0] A_SO_GP  = DW'(8'h30);
   localparam logic [DW-1:0] B_S_O    = DW'(8'h03);
   localparam logic [DW-1:0] B_S_W    = DW'(8'h04);

   logic [DW-1:0] gp;

   always_comb begin
      wmask = '0;
      omask = '0;
      gp    = '0;
      if (mode.a_bidir) begin
         omask = A_BI_O;
         wmask = A_BI_W;
      end else if (mode.a_strobed) begin
         if (mode.a_input) begin
            omask = A_SI_O;
            wmask = A_SI_W;
            if (!mode.cu_input) gp = A_SI_GP;
         end else begin
            omask = A_SO_O;
            wmask = A_SO_W;
            if (!mode.cu_input) gp = A_SO_GP;
         end
      end else if (!mode.cu_input) begin
         gp = HI_NIB;
      end
      if (mode.b_strobed) begin
         omask = omask | B_S_O;
         wmask = wmask | B_S_W;
      end else if (!mode.cl_input) begin
         gp = gp | LO3;
      end
      if (!mode.a_bidir && !mode.a_strobed && !mode.cl_input) gp = gp | BIT3;
      omask = omask | gp;
      wmask = wmask | gp;
   end
endmodule

// File: rtl/pio_portc_reg.sv
module pio_portc_reg #(
   parameter int unsigned DW = 8,
   localparam int unsigned SW = $clog2(DW)
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [DW-1:0]   clr_vec,
   input  logic            ld_en,
   input  logic [DW-1:0]   ld_data,
   input  logic            bsr_en,
   input  logic [SW-1:0]   bsr_sel,
   input  logic            bsr_val,
   input  logic [DW-1:0]   wmask,
   input  logic [DW-1:0]   hclr_vec,
   input  logic [DW-1:0]   set_vec,
   output logic [DW-1:0]   q
);
   for (genvar i = 0; i < DW; i++) begin : g_bit
      logic nxt;
      always_comb begin
         nxt = q[i];
         if (clr_vec[i]) nxt = 1'b0;
         if (ld_en && wmask[i]) nxt = ld_data[i];
         if (bsr_en && (bsr_sel == SW'(i)) && wmask[i]) nxt = bsr_val;
         if (hclr_vec[i]) nxt = 1'b0;
         if (set_vec[i]) nxt = 1'b1;
      end
      always_ff @(posedge clk) begin
         if (!rst_n) q[i] <= 1'b0;
         else        q[i] <= nxt;
      end
   end
endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
   import pio_pkg::*;
#(
   parameter int unsigned     DW          = 8,
   parameter logic [DW-1:0]   CTRL_RST    = DW'(8'h1B),
   parameter logic [DW-1:0]   WMASK_RST   = '1
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      addr,
   input  logic            wr_en,
   input  logic            rd_en,
   input  logic [DW-1:0]   wdata,
   output logic [DW-1:0]   rdata,
   input  logic [DW-1:0]   pa_in,
   output logic [DW-1:0]   pa_out,
   output logic            pa_oe,
   input  logic [DW-1:0]   pb_in,
   output logic [DW-1:0]   pb_out,
   output logic            pb_oe,
   input  logic            pb_stb,
   output logic [DW-1:0]   pc_out,
   output logic [DW-1:0]   pc_oe
);
   localparam int unsigned SW = $clog2(DW);

   if (DW != 8) begin : g_bad_width
      $error("pio_ctrl: port C layout requires DW == 8");
   end

   logic [DW-1:0] ctl_q, pa_q, pb_q, pc_q, pc_wmask, pc_omask;
   logic [DW-1:0] new_wmask, new_omask;
   pio_mode_t     cur, nxt_mode;

   assign cur      = pio_mode_t'(ctl_q[6:0]);
   assign nxt_mode = pio_mode_t'(wdata[6:0]);

   logic ctl_wr, mode_wr, bsr_wr, grp_a_chg, grp_b_chg, new_a_hs;
   logic b_hs_in, b_hs_out, hs_set, hs_intr, hs_clr;

   assign ctl_wr    = wr_en && (addr == ADR_CTL);
   assign mode_wr   = ctl_wr && wdata[7];
   assign bsr_wr    = ctl_wr && !wdata[7];
   assign grp_a_chg = mode_wr && ({nxt_mode.a_bidir, nxt_mode.a_strobed} != {cur.a_bidir, cur.a_strobed});
   assign grp_b_chg = mode_wr && (nxt_mode.b_strobed != cur.b_strobed);
   assign new_a_hs  = nxt_mode.a_bidir || nxt_mode.a_strobed;

   assign b_hs_in   = cur.b_strobed && cur.b_input;
   assign b_hs_out  = cur.b_strobed && !cur.b_input;
   assign hs_set    = pb_stb && cur.b_strobed && !mode_wr;
   assign hs_intr   = hs_set && pc_q[PC_B_EN];
   assign hs_clr    = (b_hs_in  && rd_en && (addr == ADR_B)) ||
                      (b_hs_out && wr_en && (addr == ADR_B));

   logic [DW-1:0] clr_vec, hclr_vec, set_vec;
   always_comb begin
      clr_vec = '0;
      clr_vec[7:4] = {4{grp_a_chg}};
      clr_vec[2:0] = {3{grp_b_chg}};
      clr_vec[PC_A_INTR] = grp_b_chg && !new_a_hs;
      hclr_vec = '0;
      hclr_vec[PC_B_FLAG] = hs_clr;
      hclr_vec[PC_B_INTR] = hs_clr;
      set_vec = '0;
      set_vec[PC_B_FLAG] = hs_set;
      set_vec[PC_B_INTR] = hs_intr;
   end

   pio_mask_gen #(.DW(DW)) u_mask (
      .mode  (nxt_mode),
      .wmask (new_wmask),
      .omask (new_omask)
   );

   pio_portc_reg #(.DW(DW)) u_pc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_vec  (clr_vec),
      .ld_en    (wr_en && (addr == ADR_C)),
      .ld_data  (wdata),
      .bsr_en   (bsr_wr),
      .bsr_sel  (wdata[SW:1]),
      .bsr_val  (wdata[0]),
      .wmask    (pc_wmask),
      .hclr_vec (hclr_vec),
      .set_vec  (set_vec),
      .q        (pc_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q    <= CTRL_RST;
         pc_wmask <= WMASK_RST;
         pc_omask <= '0;
         pa_q     <= '0;
         pb_q     <= '0;
      end else begin
         if (mode_wr) begin
            ctl_q    <= wdata;
            pc_wmask <= new_wmask;
            pc_omask <= new_omask;
         end
         if (grp_a_chg)                          pa_q <= '0;
         else if (wr_en && (addr == ADR_A))      pa_q <= wdata;
         if (grp_b_chg)                          pb_q <= '0;
         else if (wr_en && (addr == ADR_B) && !cur.b_input) pb_q <= wdata;
         else if (hs_set && cur.b_input)         pb_q <= pb_in;
      end
   end

   always_comb begin
      unique case (addr)
         ADR_A:   rdata = (cur.a_bidir || cur.a_input) ? pa_in : pa_q;
         ADR_B:   rdata = (cur.b_input && !cur.b_strobed) ? pb_in : pb_q;
         ADR_C:   rdata = pc_q;
         default: rdata = '1;
      endcase
   end

   assign pa_out = pa_q;
   assign pa_oe  = cur.a_bidir || !cur.a_input;
   assign pb_out = pb_q;
   assign pb_oe  = !cur.b_input;
   assign pc_out = pc_q & pc_omask;
   assign pc_oe  = pc_omask;
endmodule

// File: rtl/pio_ctrl_chk.sv
module pio_ctrl_chk #(
   parameter int unsigned DW = 8
)(
   input logic            clk,
   input logic            rst_n,
   input logic [1:0]      addr,
   input logic            wr_en,
   input logic [DW-1:0]   wdata,
   input logic            pb_stb,
   input logic [DW-1:0]   ctl_q,
   input logic [DW-1:0]   pa_q,
   input logic [DW-1:0]   pb_q,
   input logic [DW-1:0]   pc_q,
   input logic [DW-1:0]   pc_wmask
);
   logic mode_wr;
   assign mode_wr = wr_en && (addr == 2'd3) && wdata[7];

   a_r5_bsr_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd3 && !wdata[7] && !pc_wmask[wdata[3:1]] && !pb_stb) |=> $stable(pc_q));

   a_r6_grp_a_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && wdata[6:5] != ctl_q[6:5]) |=> (pa_q == '0 && pc_q[7:4] == 4'h0));

   a_r7_grp_b_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && wdata[2] != ctl_q[2]) |=> (pb_q == '0 && pc_q[2:0] == 3'h0));

   a_r3_bit3_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[6] || ctl_q[5]) |-> !pc_wmask[3]);

   a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      (pb_stb && ctl_q[2] && !mode_wr) |=> pc_q[1]);

   a_r8_intr_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pc_q[0]) && ctl_q[2] && $past(ctl_q[2])) |-> $past(pc_q[2] && pb_stb));

   a_r11_mode_blocks_stb: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr |=> !$rose(pc_q[1]));
endmodule

bind pio_ctrl pio_ctrl_chk #(.DW(DW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .addr     (addr),
   .wr_en    (wr_en),
   .wdata    (wdata),
   .pb_stb   (pb_stb),
   .ctl_q    (ctl_q),
   .pa_q     (pa_q),
   .pb_q     (pb_q),
   .pc_q     (pc_q),
   .pc_wmask (pc_wmask)
);

// File: tb/sim_pio_ctrl.sv
module sim_pio_ctrl;
   localparam int CLK_PERIOD = 10;

   localparam int S_RD = 0, S_PCOE = 1, S_PCOUT = 2, S_PAOE = 3, S_PBOE = 4, S_PAOUT = 5, S_PBOUT = 6;

   typedef struct {
      int         sel;
      logic [7:0] exp;
      string      tag;
   } item_t;

   logic       clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, pb_stb = 0;
   logic [1:0] addr = 0;
   logic [7:0] wdata = 0, pa_in = 0, pb_in = 0;
   logic [7:0] rdata, pa_out, pb_out, pc_out, pc_oe;
   logic       pa_oe, pb_oe;

   int checks = 0, failures = 0;
   bit done = 0;
   item_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   pio_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
      .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pb_stb(pb_stb),
      .pc_out(pc_out), .pc_oe(pc_oe)
   );

   function automatic logic [7:0] observe(int sel);
      case (sel)
         S_RD:    return rdata;
         S_PCOE:  return pc_oe;
         S_PCOUT: return pc_out;
         S_PAOE:  return {7'd0, pa_oe};
         S_PBOE:  return {7'd0, pb_oe};
         S_PAOUT: return pa_out;
         default: return pb_out;
      endcase
   endfunction

   // monitor: compares queued expectations shortly after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #2;
         while (q.size() > 0) begin
            item_t it;
            logic [7:0] got;
            it = q.pop_front();
            got = observe(it.sel);
            checks++;
            if (got !== it.exp) begin
               failures++;
               $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.tag, it.sel, got, it.exp);
            end
         end
      end
   end

   task automatic expect_v(int sel, logic [7:0] exp, string tag);
      item_t it;
      it.sel = sel; it.exp = exp; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; wr_en = 0; rd_en = 0; pb_stb = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1; rd_en = 0;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic wr_with_stb(logic [1:0] a, logic [7:0] d, logic [7:0] pv);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1; pb_in = pv; pb_stb = 1;
      @(negedge clk);
      wr_en = 0; pb_stb = 0;
   endtask

   task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
      @(negedge clk);
      addr = a; rd_en = 1; wr_en = 0;
      expect_v(S_RD, exp, tag);
      @(negedge clk);
      rd_en = 0;
   endtask

   task automatic stb(logic [7:0] pv);
      @(negedge clk);
      pb_in = pv; pb_stb = 1;
      @(negedge clk);
      pb_stb = 0;
   endtask

   function automatic void model(input logic [6:0] m, output logic [7:0] w, output logic [7:0] o);
      logic [7:0] g;
      w = 0; o = 0; g = 0;
      if (m[6])      begin o = 8'hA8; w = 8'h50; end
      else if (m[5]) begin
         if (m[4]) begin o = 8'h28; w = 8'h10; if (!m[3]) g = 8'hC0; end
         else      begin o = 8'h88; w = 8'h40; if (!m[3]) g = 8'h30; end
      end else if (!m[3]) g = 8'hF0;
      if (m[2]) begin o = o | 8'h03; w = w | 8'h04; end
      else if (!m[0]) g = g | 8'h07;
      if (!m[6] && !m[5] && !m[0]) g = g | 8'h08;
      o = o | g; w = w | g;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      pa_in = 8'h3E; pb_in = 8'hC7;
      do_reset();
      // R1 reset state
      expect_v(S_PCOE, 8'h00, "R1 pc_oe");
      expect_v(S_PAOE, 8'h00, "R1 pa_oe");
      expect_v(S_PBOE, 8'h00, "R1 pb_oe");
      rd(2'd3, 8'hFF, "R9 ctl read");
      rd(2'd0, 8'h3E, "R9 port A input");
      rd(2'd1, 8'hC7, "R9 port B input");
      rd(2'd2, 8'h00, "R1 port C latch");
      wr(2'd2, 8'hA5);
      rd(2'd2, 8'hA5, "R1 all writable");
      expect_v(S_PCOUT, 8'h00, "R4 no drive");
      // R2 all outputs
      wr(2'd3, 8'h80);
      expect_v(S_PCOE, 8'hFF, "R3 mode0 out");
      expect_v(S_PAOE, 8'h01, "R2 pa_oe");
      expect_v(S_PBOE, 8'h01, "R2 pb_oe");
      expect_v(S_PCOUT, 8'hA5, "R4 pc_out");
      // R5 bit set/reset
      wr(2'd2, 8'h00);
      wr(2'd3, 8'h0B); rd(2'd2, 8'h20, "R5 set bit5");
      wr(2'd3, 8'h01); rd(2'd2, 8'h21, "R5 set bit0");
      wr(2'd3, 8'h0A); rd(2'd2, 8'h01, "R5 clr bit5");
      wr(2'd3, 8'h89);
      expect_v(S_PCOE, 8'h00, "R3 all in");
      wr(2'd3, 8'h0D); rd(2'd2, 8'h01, "R5 locked bit");
      wr(2'd2, 8'hFF); rd(2'd2, 8'h01, "R4 locked write");
      // R8 port B strobed input
      wr(2'd3, 8'h86);
      expect_v(S_PCOE, 8'hFB, "R3 B strobed");
      rd(2'd2, 8'h00, "R7 clear on B change");
      stb(8'h5A); pb_in = 8'h00;
      rd(2'd2, 8'h02, "R8 flag no intr");
      rd(2'd1, 8'h5A, "R8 captured");
      rd(2'd2, 8'h00, "R8 read clears");
      wr(2'd3, 8'h05);
      stb(8'h33);
      rd(2'd2, 8'h07, "R8 flag and intr");
      expect_v(S_PCOUT, 8'h03, "R4 masked drive");
      rd(2'd1, 8'h33, "R8 second capture");
      // R11 mode word beats strobe
      wr_with_stb(2'd3, 8'h82, 8'h77);
      rd(2'd2, 8'h00, "R11 strobe blocked");
      expect_v(S_PBOE, 8'h00, "R2 B input");
      // R10 write to input port B ignored
      wr(2'd1, 8'h99);
      wr(2'd3, 8'h80);
      rd(2'd1, 8'h00, "R10 ignored write");
      wr(2'd1, 8'h99);
      rd(2'd1, 8'h99, "R9 B out latch");
      expect_v(S_PBOUT, 8'h99, "R10 pb_out");
      // R8 port B strobed output
      wr(2'd3, 8'h84);
      expect_v(S_PBOUT, 8'h00, "R7 B latch clear");
      wr(2'd3, 8'h05);
      wr(2'd1, 8'h3C);
      expect_v(S_PBOUT, 8'h3C, "R8 out data");
      stb(8'h00);
      rd(2'd2, 8'h07, "R8 ack sets");
      wr(2'd1, 8'h11);
      rd(2'd2, 8'h04, "R8 write clears");
      // R6 group A change
      wr(2'd3, 8'h80);
      wr(2'd2, 8'hFF);
      wr(2'd0, 8'hC3);
      expect_v(S_PAOUT, 8'hC3, "R12 pa_out");
      wr(2'd3, 8'hA0);
      rd(2'd2, 8'h0F, "R6 upper cleared");
      expect_v(S_PAOUT, 8'h00, "R6 A latch cleared");
      expect_v(S_PCOE, 8'hBF, "R3 A strobed out");
      wr(2'd3, 8'h07);
      rd(2'd2, 8'h0F, "R3 bit3 reserved");
      wr(2'd3, 8'hA4);
      rd(2'd2, 8'h08, "R7 bit3 kept");
      // R9 / R12 reads
      wr(2'd3, 8'h80);
      wr(2'd0, 8'h5C);
      rd(2'd0, 8'h5C, "R9 A out latch");
      pa_in = 8'hE1;
      wr(2'd3, 8'h90);
      rd(2'd0, 8'hE1, "R9 A pins");
      expect_v(S_PAOUT, 8'h5C, "R12 latch kept");
      expect_v(S_PAOE, 8'h00, "R2 A input");
      wr(2'd0, 8'h66);
      wr(2'd3, 8'h80);
      rd(2'd0, 8'h66, "R12 write while input");
      wr(2'd3, 8'hC0);
      expect_v(S_PAOE, 8'h01, "R2 bidir");
      rd(2'd0, 8'hE1, "R9 bidir pins");
      // R3 every mode word
      for (int m = 0; m < 128; m++) begin
         logic [7:0] w, o;
         model(7'(m), w, o);
         do_reset();
         wr(2'd3, {1'b1, 7'(m)});
         expect_v(S_PCOE, o, "R3 sweep drive");
         wr(2'd2, 8'hFF);
         rd(2'd2, w, "R3 sweep writable");
         expect_v(S_PCOUT, w & o, "R4 sweep out");
      end
      repeat (3) @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule